// File: doc/BRIEF.md
# Serial Flash Slave Command Front-End

This block is the command front end of a serial memory slave. It sits behind an active-low chip select, a serial clock and four shared data pins. All of these are brought into the system clock domain through a synchronizer chain. While the block is selected it shifts in an 8-bit instruction, most significant bit first, and decodes four operations: set and clear of the write-enable latch, a status read and a status write. It reports each decoded instruction with a one-cycle strobe and keeps the 8-bit status register on an output port.

Two status bits change how the pins are read. The quad-enable bit turns the write-protect pin and the hold pin into plain data lanes, so their control meaning no longer applies. The protect bit works with a low level on the write-protect pin to freeze the upper six status bits against writes. When the quad-enable bit is clear, a low hold pin pauses the serial sequence at its current bit and releases the output lane. The memory array, program and erase, multi-lane read paths and power-down modes are not part of this block.

Top module: `sfc_cmd_frontend`

## Requirements
- R1: While chip select is high, every io_oe bit is 0 and clock edges have no effect: no strobe is issued and the status register does not change.
- R2: After reset, no instruction is accepted until chip select has gone high and then low. Chip select held low through reset therefore leaves the block idle.
- R3: In single-lane mode, input bits are taken from io_in[0], MSB first, at the rising edge of SCK. Changes of io_in[0] while SCK is high have no effect.
- R4: On the 8th rising edge of a frame, cmd_strobe pulses for one clock and cmd_code gives the decoded instruction: 1 = write enable (06h), 2 = write disable (04h), 3 = read status (05h), 4 = write status (01h), 5 = any other opcode, 0 = none since reset.
- R5: Write enable sets status bit 1 (write-enable latch) and write disable clears it. Either one takes effect when chip select rises, and only if exactly 8 bits were clocked in the frame.
- R6: Read status drives the status register MSB first on io_out[1], with io_oe = 0010b. A new bit is driven at each falling edge of SCK, starting at the falling edge that follows the 8th rising edge. The byte repeats for as long as chip select stays low.
- R7: Write status takes effect when chip select rises, and only if exactly 16 bits were clocked and the write-enable latch is set. It then loads bits 7..2 from the data byte, leaves bit 1 and bit 0 free of the data, and clears the latch. In any other case the register does not change.
- R8: When status bit 7 (protect) is 1, the quad-enable bit is 0 and io_in[2] is low, a valid write status leaves bits 7..2 unchanged and still clears the latch. With protect at 0, bits 7..2 are writable at either pin level.
- R9: With quad-enable 0 and chip select low, a low io_in[3] (hold) releases io_oe and makes SCK edges have no effect. When hold returns high, the sequence resumes at the bit where it paused.
- R10: When status bit 6 (quad-enable) is 1, io_in[2] no longer locks the status register and io_in[3] no longer pauses the sequence.
- R11: An unrecognised opcode is ignored. Later bits in the same frame have no effect, io_oe stays 0 and the status register does not change until chip select goes high.
- R12: Reset clears the status register to 00h, io_oe to 0 and cmd_code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to sample all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the master |
| io_in | input | 4 | Pin inputs: lane 0 data in, lane 2 write-protect or data, lane 3 hold or data |
| io_out | output | 4 | Pin output values; only lane 1 is ever driven |
| io_oe | output | 4 | Per-lane output enable |
| cmd_strobe | output | 1 | One-cycle pulse when an instruction byte completes |
| cmd_code | output | 3 | Code of the last decoded instruction |
| status_q | output | 8 | Status register: 7 protect, 6 quad-enable, 5..2 block protect, 1 write-enable latch, 0 busy |

## Verification
Each pin change passes through two synchronizer stages and one edge-detect register. After an SCK falling edge the read bit appears on io_out[1] three clocks later, and io_oe follows one clock after that. The bench holds each SCK phase for ten clocks, so the monitor samples the read lane at the next rising edge, well after it has settled. Status effects take place at the chip-select rise, so the bench checks status_q twenty clocks after raising chip select. Hold and deselect checks wait twelve clocks before they look at io_oe.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // status register geometry
    localparam int SR_W      = 8;
    localparam int SR_PROT   = 7;
    localparam int SR_QE     = 6;
    localparam int SR_WEL    = 1;
    localparam int SR_BUSY   = 0;
    localparam logic [SR_W-1:0] SR_WMASK = 8'hFC;

    // pin lanes
    localparam int LANES     = 4;
    localparam int LANE_SI   = 0;
    localparam int LANE_SO   = 1;
    localparam int LANE_WP   = 2;
    localparam int LANE_HOLD = 3;

    // frame lengths that make a command valid at deselect
    localparam int OP_BITS    = 8;
    localparam int WRSR_BITS  = OP_BITS + SR_W;
    localparam int CNT_W      = $clog2(WRSR_BITS + 1);
    localparam int IDX_W      = $clog2(SR_W);

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_WREN  = 3'd1,
        CMD_WRDI  = 3'd2,
        CMD_RDSR  = 3'd3,
        CMD_WRSR  = 3'd4,
        CMD_OTHER = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_WDATA,
        PH_RDOUT,
        PH_QUIET
    } phase_e;

    typedef struct packed {
        logic             cs_n;
        logic             sck;
        logic [LANES-1:0] io;
    } pins_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OPC_WREN: return CMD_WREN;
            OPC_WRDI: return CMD_WRDI;
            OPC_RDSR: return CMD_RDSR;
            OPC_WRSR: return CMD_WRSR;
            default:  return CMD_OTHER;
        endcase
    endfunction

    // phase entered once the instruction byte is complete
    function automatic phase_e phase_after(input cmd_e c);
        case (c)
            CMD_WRSR: return PH_WDATA;
            CMD_RDSR: return PH_RDOUT;
            default:  return PH_QUIET;
        endcase
    endfunction

    // writable bits come from the new byte, read-only bits stay
    function automatic logic [SR_W-1:0] merge_status(input logic [SR_W-1:0] cur,
                                                     input logic [SR_W-1:0] wr);
        return (wr & SR_WMASK) | (cur & ~SR_WMASK);
    endfunction

endpackage

// File: rtl/sfc_pin_sync.sv
module sfc_pin_sync
    import sfc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pin_raw,
    output pins_t pin_s
);
    localparam int PW = $bits(pins_t);

    logic [STAGES-1:0][PW-1:0] stg;

    // reset to all-zero so a chip select held low through reset
    // never looks like a falling edge afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= pin_raw;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
        end
    end

    assign pin_s = pins_t'(stg[STAGES-1]);

endmodule

// File: rtl/sfc_serial_frame.sv
module sfc_serial_frame
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             sck_s,
    input  logic             si_s,
    input  logic             hold_n_s,
    input  logic             qe,
    input  logic [SR_W-1:0]  status,
    output logic             act,
    output logic             hold_act,
    output logic             cs_rise,
    output logic [CNT_W-1:0] bit_cnt,
    output cmd_e             cur_cmd,
    output logic [SR_W-1:0]  wr_byte,
    output logic             out_bit,
    output logic             drive_en,
    output logic             strobe,
    output cmd_e             strobe_cmd
);
    logic            cs_prev;
    logic            sck_prev;
    logic            armed;
    logic            cs_fall;
    logic            sel;
    logic            sck_rise;
    logic            sck_fall;
    logic [7:0]      shreg;
    logic [7:0]      in_byte;
    logic [IDX_W-1:0] rd_idx;
    phase_e          phase;

    assign cs_fall  = cs_prev & ~cs_n_s;
    assign cs_rise  = ~cs_prev & cs_n_s;
    assign sel      = ~cs_n_s & (armed | cs_fall);
    assign hold_act = sel & ~qe & ~hold_n_s;
    assign act      = sel & ~hold_act;
    // sck_prev keeps following the pin during a pause, so edges seen
    // while held are dropped and no false edge appears on release
    assign sck_rise = act & sck_s & ~sck_prev;
    assign sck_fall = act & ~sck_s & sck_prev;
    assign in_byte  = {shreg[6:0], si_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev    <= 1'b0;
            sck_prev   <= 1'b0;
            armed      <= 1'b0;
            shreg      <= '0;
            bit_cnt    <= '0;
            phase      <= PH_OPCODE;
            cur_cmd    <= CMD_NONE;
            wr_byte    <= '0;
            out_bit    <= 1'b0;
            drive_en   <= 1'b0;
            rd_idx     <= '0;
            strobe     <= 1'b0;
            strobe_cmd <= CMD_NONE;
        end else begin
            cs_prev  <= cs_n_s;
            sck_prev <= sck_s;
            strobe   <= 1'b0;
            if (cs_fall) begin
                armed <= 1'b1;
            end
            if (!sel) begin
                bit_cnt  <= '0;
                phase    <= PH_OPCODE;
                cur_cmd  <= CMD_NONE;
                drive_en <= 1'b0;
                rd_idx   <= '0;
            end else begin
                if (sck_rise) begin
                    shreg <= in_byte;
                    if (bit_cnt != {CNT_W{1'b1}}) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (phase == PH_OPCODE && bit_cnt == CNT_W'(OP_BITS - 1)) begin
                        cur_cmd    <= decode_op(in_byte);
                        phase      <= phase_after(decode_op(in_byte));
                        strobe     <= 1'b1;
                        strobe_cmd <= decode_op(in_byte);
                    end
                    if (phase == PH_WDATA && bit_cnt == CNT_W'(WRSR_BITS - 1)) begin
                        wr_byte <= in_byte;
                    end
                end
                if (sck_fall && phase == PH_RDOUT) begin
                    out_bit  <= status[IDX_W'(SR_W - 1) - rd_idx];
                    rd_idx   <= rd_idx + 1'b1;
                    drive_en <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sfc_status_reg.sv
module sfc_status_reg
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  cmd_e             cur_cmd,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [SR_W-1:0]  wr_byte,
    input  logic             wp_n_s,
    output logic             lock,
    output logic [SR_W-1:0]  status
);
    logic            len8;
    logic            len16;
    logic [SR_W-1:0] st_nxt;

    assign len8  = bit_cnt == CNT_W'(OP_BITS);
    assign len16 = bit_cnt == CNT_W'(WRSR_BITS);
    // the pin only guards the register when it is not a data lane
    assign lock  = status[SR_PROT] & ~status[SR_QE] & ~wp_n_s;

    always_comb begin
        st_nxt = status;
        if (commit) begin
            case (cur_cmd)
                CMD_WREN: if (len8) st_nxt[SR_WEL] = 1'b1;
                CMD_WRDI: if (len8) st_nxt[SR_WEL] = 1'b0;
                CMD_WRSR: begin
                    if (len16 && status[SR_WEL]) begin
                        if (!lock) begin
                            st_nxt = merge_status(status, wr_byte);
                        end
                        st_nxt[SR_WEL] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        st_nxt[SR_BUSY] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= st_nxt;
        end
    end

endmodule

// File: rtl/sfc_cmd_frontend.sv
module sfc_cmd_frontend
    import sfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [LANES-1:0] io_in,
    output logic [LANES-1:0] io_out,
    output logic [LANES-1:0] io_oe,
    output logic             cmd_strobe,
    output logic [2:0]       cmd_code,
    output logic [SR_W-1:0]  status_q
);
    pins_t            pin_raw;
    pins_t            pin_s;
    logic             act;
    logic             hold_act;
    logic             cs_rise;
    logic [CNT_W-1:0] bit_cnt;
    cmd_e             cur_cmd;
    logic [SR_W-1:0]  wr_byte;
    logic             out_bit;
    logic             drive_en;
    logic             strobe;
    cmd_e             strobe_cmd;
    logic             lock;
    logic [SR_W-1:0]  status;

    assign pin_raw.cs_n = cs_n;
    assign pin_raw.sck  = sck;
    assign pin_raw.io   = io_in;

    sfc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_raw),
        .pin_s   (pin_s)
    );

    sfc_serial_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .cs_n_s     (pin_s.cs_n),
        .sck_s      (pin_s.sck),
        .si_s       (pin_s.io[LANE_SI]),
        .hold_n_s   (pin_s.io[LANE_HOLD]),
        .qe         (status[SR_QE]),
        .status     (status),
        .act        (act),
        .hold_act   (hold_act),
        .cs_rise    (cs_rise),
        .bit_cnt    (bit_cnt),
        .cur_cmd    (cur_cmd),
        .wr_byte    (wr_byte),
        .out_bit    (out_bit),
        .drive_en   (drive_en),
        .strobe     (strobe),
        .strobe_cmd (strobe_cmd)
    );

    sfc_status_reg u_status (
        .clk     (clk),
        .rst     (rst),
        .commit  (cs_rise),
        .cur_cmd (cur_cmd),
        .bit_cnt (bit_cnt),
        .wr_byte (wr_byte),
        .wp_n_s  (pin_s.io[LANE_WP]),
        .lock    (lock),
        .status  (status)
    );

    // only the serial-out lane ever drives in this command set
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        if (ln == LANE_SO) begin : g_drv
            logic oe_q;
            always_ff @(posedge clk) begin
                if (rst) oe_q <= 1'b0;
                else     oe_q <= drive_en & act;
            end
            assign io_oe[ln]  = oe_q;
            assign io_out[ln] = out_bit;
        end else begin : g_in
            assign io_oe[ln]  = 1'b0;
            assign io_out[ln] = 1'b0;
        end
    end

    assign cmd_strobe = strobe;
    assign cmd_code   = strobe_cmd;
    assign status_q   = status;

endmodule

// File: rtl/sfc_cmd_frontend_chk.sv
module sfc_cmd_frontend_chk
    import sfc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_hi,
    input logic             cs_rise,
    input logic             hold_act,
    input logic             lock,
    input logic             cmd_strobe,
    input logic [LANES-1:0] io_oe,
    input logic [SR_W-1:0]  status_q
);
    // R1: a deselected slave releases every lane
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> (io_oe == '0));

    // R6: reads use the serial-out lane only
    a_r6_single_lane: assert property (@(posedge clk) disable iff (rst)
        (io_oe & ~(LANES'(1) << LANE_SO)) == '0);

    // R9: a pause releases the output
    a_r9_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        hold_act |=> (io_oe == '0));

    // R4: strobe lasts a single clock
    a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);

    // R5: status changes only right after a deselect
    a_r5_commit_at_deselect: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q) |-> $past(cs_rise));

    // R7: upper bits move only while the latch was set
    a_r7_wel_gate: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q[SR_W-1:2]) |-> $past(status_q[SR_WEL]));

    // R8: a locked register keeps its upper bits
    a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
        $past(lock) |-> $stable(status_q[SR_W-1:2]));

endmodule

bind sfc_cmd_frontend sfc_cmd_frontend_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_hi      (pin_s.cs_n),
    .cs_rise    (cs_rise),
    .hold_act   (hold_act),
    .lock       (lock),
    .cmd_strobe (cmd_strobe),
    .io_oe      (io_oe),
    .status_q   (status_q)
);

// File: tb/sfc_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module sfc_cmd_frontend_tb_top;
    import sfc_pkg::*;

    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n_r = 1'b0;
    logic       sck_r = 1'b0;
    logic [3:0] io_r = 4'b1100;
    logic [3:0] io_out;
    logic [3:0] io_oe;
    logic       cmd_strobe;
    logic [2:0] cmd_code;
    logic [7:0] status_q;

    int         checks = 0;
    int         fails = 0;
    int         n_strobe = 0;
    logic [2:0] last_code = 3'd0;
    logic [7:0] exp_q[$];
    bit         done = 0;

    always #2 clk = ~clk;

    sfc_cmd_frontend dut_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n_r),
        .sck        (sck_r),
        .io_in      (io_r),
        .io_out     (io_out),
        .io_oe      (io_oe),
        .cmd_strobe (cmd_strobe),
        .cmd_code   (cmd_code),
        .status_q   (status_q)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        io_r[0] = b;
        idle(HALF);
        sck_r = 1'b1;
        idle(HALF);
        sck_r = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic read_clk();
        idle(HALF);
        sck_r = 1'b1;
        idle(HALF);
        sck_r = 1'b0;
    endtask

    task automatic sel();
        cs_n_r = 1'b0;
        idle(HALF);
    endtask

    task automatic desel();
        idle(HALF);
        cs_n_r = 1'b1;
        idle(2 * HALF);
    endtask

    task automatic cmd8(input logic [7:0] op);
        sel();
        send_byte(op);
        desel();
    endtask

    task automatic wrsr(input logic [7:0] d);
        sel();
        send_byte(OPC_WRSR);
        send_byte(d);
        desel();
    endtask

    // driver: queue the expected bytes, then clock them out
    task automatic rdsr(input int n, input logic [7:0] expv);
        for (int i = 0; i < n; i++) exp_q.push_back(expv);
        sel();
        send_byte(OPC_RDSR);
        repeat (8 * n) read_clk();
        desel();
    endtask

    // monitor: assemble read bytes on the master's sampling edge
    initial begin
        int         mcnt;
        logic [7:0] got;
        logic [7:0] e;
        mcnt = 0;
        got = '0;
        forever begin
            @(posedge sck_r or posedge cs_n_r);
            if (cs_n_r) begin
                mcnt = 0;
            end else if (io_oe[1]) begin
                got = {got[6:0], io_out[1]};
                mcnt++;
                if (mcnt == 8) begin
                    mcnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected read byte", int'(got), 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(got == e, "R6 read byte (R9 resume)", int'(got), int'(e));
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cmd_strobe) begin
            n_strobe++;
            last_code <= cmd_code;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        idle(5);
        rst = 1'b0;
        idle(5);

        // R12: reset state
        chk(status_q == 8'h00, "R12 status after reset", status_q, 8'h00);
        chk(io_oe == 4'h0, "R12 oe after reset", io_oe, 0);
        chk(cmd_code == 3'd0, "R12 code after reset", cmd_code, 0);

        // R2: chip select held low through reset is not a frame start
        send_byte(OPC_WREN);
        cs_n_r = 1'b1;
        idle(2 * HALF);
        chk(status_q[1] == 1'b0, "R2 no arm before first select", status_q[1], 0);
        chk(n_strobe == 0, "R2 no strobe before first select", n_strobe, 0);

        // R5/R4: write enable
        cmd8(OPC_WREN);
        chk(status_q == 8'h02, "R5 write enable sets latch", status_q, 8'h02);
        chk(n_strobe == 1, "R4 one strobe per opcode", n_strobe, 1);
        chk(last_code == 3'd1, "R4 code write enable", last_code, 1);

        // R6: repeated status read
        rdsr(2, 8'h02);
        chk(io_oe == 4'h0, "R1 released after read", io_oe, 0);
        chk(last_code == 3'd3, "R4 code read status", last_code, 3);

        // R5: a 9-bit write disable frame is not executed
        sel();
        send_byte(OPC_WRDI);
        send_bit(1'b0);
        desel();
        chk(status_q == 8'h02, "R5 wrong length ignored", status_q, 8'h02);
        cmd8(OPC_WRDI);
        chk(status_q == 8'h00, "R5 write disable clears latch", status_q, 8'h00);

        // R7: latch required, read-only bits kept, latch cleared
        wrsr(8'h3C);
        chk(status_q == 8'h00, "R7 no write without latch", status_q, 8'h00);
        cmd8(OPC_WREN);
        wrsr(8'h3F);
        chk(status_q == 8'h3C, "R7 write status", status_q, 8'h3C);
        chk(last_code == 3'd4, "R4 code write status", last_code, 4);
        cmd8(OPC_WREN);
        sel();
        send_byte(OPC_WRSR);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        desel();
        chk(status_q == 8'h3E, "R7 short write ignored", status_q, 8'h3E);
        cmd8(OPC_WRDI);

        // R8: protection with the pin low
        cmd8(OPC_WREN);
        wrsr(8'hA0);
        chk(status_q == 8'hA0, "R8 set protect", status_q, 8'hA0);
        io_r[2] = 1'b0;
        cmd8(OPC_WREN);
        wrsr(8'h00);
        chk(status_q == 8'hA0, "R8 locked write keeps bits", status_q, 8'hA0);
        io_r[2] = 1'b1;
        cmd8(OPC_WREN);
        wrsr(8'h00);
        chk(status_q == 8'h00, "R8 pin high unlocks", status_q, 8'h00);
        io_r[2] = 1'b0;
        cmd8(OPC_WREN);
        wrsr(8'h14);
        chk(status_q == 8'h14, "R8 protect clear writable", status_q, 8'h14);
        io_r[2] = 1'b1;

        // R9: pause in the middle of a read
        exp_q.push_back(8'h14);
        exp_q.push_back(8'h14);
        sel();
        send_byte(OPC_RDSR);
        repeat (3) read_clk();
        io_r[3] = 1'b0;
        idle(12);
        chk(io_oe == 4'h0, "R9 hold releases lane", io_oe, 0);
        repeat (2) read_clk();
        chk(io_oe == 4'h0, "R9 edges during hold", io_oe, 0);
        io_r[3] = 1'b1;
        idle(12);
        chk(io_oe == 4'h2, "R9 lane back after hold", io_oe, 2);
        repeat (13) read_clk();
        desel();

        // R10: quad-enable turns control pins into data lanes
        cmd8(OPC_WREN);
        wrsr(8'h40);
        chk(status_q == 8'h40, "R10 set quad enable", status_q, 8'h40);
        io_r[3:2] = 2'b00;
        exp_q.push_back(8'h40);
        sel();
        send_byte(OPC_RDSR);
        read_clk();
        chk(io_oe == 4'h2, "R10 hold pin ignored", io_oe, 2);
        repeat (7) read_clk();
        desel();
        cmd8(OPC_WREN);
        wrsr(8'hC0);
        cmd8(OPC_WREN);
        wrsr(8'hC8);
        chk(status_q == 8'hC8, "R10 protect pin ignored", status_q, 8'hC8);
        cmd8(OPC_WREN);
        wrsr(8'h00);
        chk(status_q == 8'h00, "R10 clear quad enable", status_q, 8'h00);
        io_r[3:2] = 2'b11;

        // R11: unknown opcode, later bits ignored
        sel();
        send_byte(8'h9F);
        send_byte(OPC_WREN);
        chk(io_oe == 4'h0, "R11 no drive on unknown", io_oe, 0);
        chk(last_code == 3'd5, "R4 code unknown", last_code, 5);
        desel();
        chk(status_q == 8'h00, "R11 status untouched", status_q, 8'h00);

        // R1: clocking while deselected
        s0 = n_strobe;
        send_byte(OPC_WREN);
        idle(2 * HALF);
        chk(n_strobe == s0, "R1 no strobe while deselected", n_strobe, s0);
        chk(status_q == 8'h00, "R1 status while deselected", status_q, 8'h00);

        // R3: data moving while SCK is high is not sampled
        sel();
        for (int i = 7; i >= 0; i--) begin
            io_r[0] = OPC_WREN[i];
            idle(HALF);
            sck_r = 1'b1;
            idle(HALF / 2);
            io_r[0] = ~OPC_WREN[i];
            idle(HALF - HALF / 2);
            sck_r = 1'b0;
        end
        desel();
        chk(status_q == 8'h02, "R3 rising-edge sampling", status_q, 8'h02);

        chk(exp_q.size() == 0, "R6 all expected bytes read", exp_q.size(), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule